// File: doc/BRIEF.md
# Instruction Parcel Prefetch Buffer

This block keeps the decode stage supplied with 16-bit instruction parcels. It asks an instruction-memory port for aligned 32-bit words, one at a time and at ascending addresses, splits each returned word into two parcels and queues them in a four-parcel (eight-byte) ring. The decoder looks at the head parcel and takes it with a one-cycle strobe, at most one per cycle. A static byte-order input selects the order in which the two halves of a word enter the ring. A select input lets an on-chip ROM source drive the parcel output in place of the ring; while it is selected the ring is not popped.

A taken branch is signalled by a flush strobe with a halfword-aligned byte target address. The flush empties the ring unconditionally, without looking for the target among the held parcels. Fetching restarts at the word holding the target. When the target is the upper parcel of that word, the lower parcel of the first refilled word is thrown away. A word whose request was already in flight when the flush arrived is dropped on return.

The fetch controller has three states. FS_FILL may issue a request. FS_WAIT has one request outstanding whose data will be kept. FS_DROP has one request outstanding whose data will be discarded. The transitions are:
- FS_FILL to FS_WAIT when a request is accepted.
- FS_WAIT to FS_FILL when the data returns.
- FS_WAIT to FS_DROP when a flush arrives before the data.
- FS_DROP to FS_FILL when the stale data returns.
- FS_FILL stays in FS_FILL on a flush.

Top module: `parcel_prefetch`

## Requirements
- R1: After reset the parcel output is invalid, and a request for byte address 0 is presented.
- R2: Requests carry word-aligned addresses that rise by 4 from one to the next. After a flush the next request is for the target with its two low bits cleared. At most one request is outstanding; the cycle after an acceptance shows no request.
- R3: With big_endian low, data bits 15:0 of a word are delivered before bits 31:16.
- R4: With big_endian high, data bits 31:16 of a word are delivered before bits 15:0.
- R5: Parcels are delivered in address order. A high dec_take while out_valid is high and rom_sel is low consumes exactly one parcel.
- R6: The ring never holds more than four parcels. A request is raised only when at least two slots are free, counting a parcel popped in the same cycle, so a full ring stops requests.
- R7: In the cycle after a flush the ring is empty (out_valid low when rom_sel is low). The first parcel delivered afterwards is the one at the target.
- R8: For a target with address bit 1 set, the lower parcel of the first refilled word is discarded, and the target parcel comes out first.
- R9: Data returning for a request issued before a flush never enters the ring.
- R10: While rom_sel is high, out_valid and out_parcel follow rom_valid and rom_parcel, and dec_take does not remove a parcel from the ring.
- R11: A flush and a dec_take in the same cycle act as a flush alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte order: 1 swaps the halves of each word |
| flush | input | 1 | Taken-branch strobe |
| flush_addr | input | ADDR_W | Byte address of the branch target (halfword aligned) |
| req_valid | output | 1 | Fetch request |
| req_addr | output | ADDR_W | Word-aligned fetch byte address |
| req_ready | input | 1 | Memory accepts the request |
| resp_valid | input | 1 | Returned word is valid |
| resp_data | input | 2*PARCEL_W | Returned word |
| dec_take | input | 1 | Decoder consumes the presented parcel |
| rom_sel | input | 1 | Select the ROM parcel source |
| rom_valid | input | 1 | ROM parcel valid |
| rom_parcel | input | PARCEL_W | ROM parcel |
| out_valid | output | 1 | Presented parcel is valid |
| out_parcel | output | PARCEL_W | Parcel presented to the decoder |

## Verification
Memory holds an address-derived value in each parcel. The memory model stores words in the order the byte-order input expects, so the same parcel stream is expected in both orders, and a missing swap shows up as an exchanged pair.

Decoder strobes are random, which makes pops collide with refills and the ring run both near empty and full. A directed stall shows that requests stop when the ring is full. The memory model adds extra latency on the first word of each 16-byte line, so flushes land both while a word is in flight and as it returns. This separates dropped stale data from data that was wrongly kept.

Flush targets alternate at random between the lower and upper parcel of a word, which exercises the discard of the lower parcel. ROM-select cycles check that the ring head is preserved across them. Both byte orders are run from reset.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        FS_FILL = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/parcel_ring.sv
module parcel_ring #(
    parameter int DEPTH    = 4,
    parameter int PARCEL_W = 16,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [1:0]          push_n,
    input  logic [PARCEL_W-1:0] push_a,
    input  logic [PARCEL_W-1:0] push_b,
    input  logic                pop,
    output logic [PARCEL_W-1:0] head,
    output logic [CNT_W-1:0]    count
);
    logic [PARCEL_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]    rd_ptr;
    logic [PTR_W-1:0]    wr_idx;
    logic [PTR_W-1:0]    wr_idx1;

    assign wr_idx  = rd_ptr + count[PTR_W-1:0];
    assign wr_idx1 = wr_idx + PTR_W'(1);
    assign head    = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (!clr && push_n != 2'd0) slot[wr_idx] <= push_a;
        if (!clr && push_n == 2'd2) slot[wr_idx1] <= push_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import pf_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              space_ok,
    input  logic              req_ready,
    input  logic              resp_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              deliver,
    output logic              skip_lo,
    output fetch_state_t      state
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    fetch_state_t      next_state;
    logic [ADDR_W-1:0] fetch_addr;
    logic              accept;

    assign accept = req_valid && req_ready;

    always_comb begin
        next_state = state;
        unique case (state)
            FS_FILL: if (!flush && accept) next_state = FS_WAIT;
            FS_WAIT: begin
                if (resp_valid)  next_state = FS_FILL;
                else if (flush)  next_state = FS_DROP;
            end
            FS_DROP: if (resp_valid) next_state = FS_FILL;
            default: next_state = FS_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FS_FILL;
            fetch_addr <= {RESET_ADDR[ADDR_W-1:2], 2'b00};
            skip_lo    <= 1'b0;
        end else begin
            state <= next_state;
            if (flush) begin
                fetch_addr <= {flush_addr[ADDR_W-1:2], 2'b00};
                skip_lo    <= flush_addr[1];
            end else begin
                if (accept)  fetch_addr <= fetch_addr + WORD_BYTES;
                if (deliver) skip_lo    <= 1'b0;
            end
        end
    end

    always_comb begin
        req_valid = (state == FS_FILL) && !flush && space_ok;
        req_addr  = fetch_addr;
        deliver   = (state == FS_WAIT) && resp_valid && !flush;
    end
endmodule

// File: rtl/parcel_prefetch.sv
module parcel_prefetch
    import pf_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PARCEL_W   = 16,
    parameter int          DEPTH      = 4,
    parameter logic [31:0] RESET_ADDR = 32'h0,
    localparam int         WORD_W     = 2 * PARCEL_W,
    localparam int         CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                big_endian,
    input  logic                flush,
    input  logic [ADDR_W-1:0]   flush_addr,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    input  logic                req_ready,
    input  logic                resp_valid,
    input  logic [WORD_W-1:0]   resp_data,
    input  logic                dec_take,
    input  logic                rom_sel,
    input  logic                rom_valid,
    input  logic [PARCEL_W-1:0] rom_parcel,
    output logic                out_valid,
    output logic [PARCEL_W-1:0] out_parcel
);
    logic [CNT_W-1:0]    buf_count;
    logic [PARCEL_W-1:0] buf_head;
    logic [PARCEL_W-1:0] first_p, second_p;
    logic [PARCEL_W-1:0] push_a;
    logic [1:0]          push_n;
    logic                pop, deliver, skip_lo, space_ok;
    logic [CNT_W:0]      free_slots;
    fetch_state_t        state;

    // parcel order inside a word
    assign first_p  = big_endian ? resp_data[WORD_W-1:PARCEL_W] : resp_data[PARCEL_W-1:0];
    assign second_p = big_endian ? resp_data[PARCEL_W-1:0] : resp_data[WORD_W-1:PARCEL_W];

    assign push_a = skip_lo ? second_p : first_p;
    assign push_n = !deliver ? 2'd0 : (skip_lo ? 2'd1 : 2'd2);

    assign pop = dec_take && !rom_sel && !flush && (buf_count != '0);

    assign free_slots = (CNT_W+1)'(DEPTH) - {1'b0, buf_count} + (CNT_W+1)'(pop);
    assign space_ok   = free_slots >= (CNT_W+1)'(2);

    fetch_ctrl #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .space_ok   (space_ok),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .deliver    (deliver),
        .skip_lo    (skip_lo),
        .state      (state)
    );

    parcel_ring #(.DEPTH(DEPTH), .PARCEL_W(PARCEL_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush),
        .push_n (push_n),
        .push_a (push_a),
        .push_b (second_p),
        .pop    (pop),
        .head   (buf_head),
        .count  (buf_count)
    );

    always_comb begin
        if (rom_sel) begin
            out_valid  = rom_valid;
            out_parcel = rom_parcel;
        end else begin
            out_valid  = buf_count != '0;
            out_parcel = buf_head;
        end
    end
endmodule

// File: rtl/parcel_prefetch_chk.sv
module parcel_prefetch_chk
    import pf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             rom_sel,
    input logic [1:0]       push_n,
    input logic [CNT_W-1:0] buf_count,
    input fetch_state_t     state
);
    // R6
    ring_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CNT_W'(DEPTH));

    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> buf_count == '0);

    // R9
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_DROP && resp_valid) |=> buf_count <= $past(buf_count));

    // R10
    rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && !flush && push_n == 2'd0) |=> buf_count == $past(buf_count));
endmodule

bind parcel_prefetch parcel_prefetch_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .rom_sel    (rom_sel),
    .push_n     (push_n),
    .buf_count  (buf_count),
    .state      (state)
);

// File: tb/tb_parcel_prefetch.sv
module tb_parcel_prefetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ready = 1'b0;
    logic        resp_valid = 1'b0;
    logic [31:0] resp_data = '0;
    logic        dec_take = 1'b0;
    logic        rom_sel = 1'b0;
    logic        rom_valid = 1'b0;
    logic [15:0] rom_parcel = '0;
    logic        out_valid;
    logic [15:0] out_parcel;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_h;
    logic [31:0] exp_fetch;
    bit first_after = 0;
    bit first_odd = 0;
    bit just_flushed = 0;

    always #4 clk = ~clk;

    parcel_prefetch dut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .flush(flush),
        .flush_addr(flush_addr), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .dec_take(dec_take), .rom_sel(rom_sel), .rom_valid(rom_valid),
        .rom_parcel(rom_parcel), .out_valid(out_valid), .out_parcel(out_parcel)
    );

    function automatic logic [15:0] pval(input logic [31:0] h);
        return (h[15:0] * 16'h9E37) ^ 16'h1234;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic be);
        logic [31:0] h;
        h = a >> 1;
        return be ? {pval(h), pval(h + 1)} : {pval(h + 1), pval(h)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: one word per two cycles, extra latency at line start
    initial begin
        int delay;
        bit busy;
        busy = 0;
        delay = 0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                busy = 0;
                resp_valid <= 1'b0;
                req_ready  <= 1'b0;
                exp_fetch  = 32'h0;
            end else begin
                if (flush) exp_fetch = {flush_addr[31:2], 2'b00};
                if (resp_valid) begin
                    resp_valid <= 1'b0;
                    req_ready  <= 1'b1;
                    busy = 0;
                end else if (busy) begin
                    if (delay == 0) resp_valid <= 1'b1;
                    else delay--;
                end else if (req_valid && req_ready) begin
                    // R2: sequential word-aligned requests
                    chk("R2", req_addr, exp_fetch);
                    exp_fetch = exp_fetch + 4;
                    resp_data <= mem_word(req_addr, big_endian);
                    req_ready <= 1'b0;
                    busy = 1;
                    delay = (req_addr[3:2] == 2'b00) ? 3 : 0;
                    if (delay == 0) resp_valid <= 1'b1;
                    else delay--;
                end else begin
                    req_ready <= 1'b1;
                end
            end
        end
    end

    task automatic cyc(input bit en_take, input bit en_flush, input bit en_rom,
                       input bit force_flush, input logic [31:0] tgt_h);
        bit do_flush;
        logic [31:0] th;
        @(negedge clk);
        flush = 1'b0;
        dec_take = 1'b0;
        rom_sel = en_rom && ($urandom % 8 == 0);
        rom_valid = $urandom % 2;
        rom_parcel = 16'($urandom);
        #1;
        if (just_flushed && !rom_sel) chk("R7 empty", {31'b0, out_valid}, 32'd0);
        just_flushed = 0;
        if (rom_sel) begin
            chk("R10 parcel", {16'b0, out_parcel}, {16'b0, rom_parcel});
            chk("R10 valid", {31'b0, out_valid}, {31'b0, rom_valid});
        end
        do_flush = force_flush || (en_flush && ($urandom % 40 == 0));
        if (do_flush) begin
            th = force_flush ? tgt_h : ($urandom % 2048);
            flush = 1'b1;
            flush_addr = th << 1;
            dec_take = $urandom % 2; // R11: take ignored under flush
            exp_h = th;
            first_after = 1;
            first_odd = th[0];
            just_flushed = 1;
        end else begin
            dec_take = en_take && ($urandom % 4 != 0);
            if (dec_take && !rom_sel && out_valid) begin
                // R5: in-order delivery, one parcel per take
                if (first_after)
                    chk(first_odd ? "R8 first parcel" : "R7 first parcel",
                        {16'b0, out_parcel}, {16'b0, pval(exp_h)});
                else
                    chk(big_endian ? "R4 R5 parcel" : "R3 R5 parcel",
                        {16'b0, out_parcel}, {16'b0, pval(exp_h)});
                exp_h++;
                first_after = 0;
            end
        end
    endtask

    task automatic run_phase(input logic be);
        rst_n = 1'b0;
        big_endian = be;
        flush = 1'b0;
        dec_take = 1'b0;
        rom_sel = 1'b0;
        exp_h = 0;
        first_after = 0;
        just_flushed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 req_valid", {31'b0, req_valid}, 32'd1);
        chk("R1 req_addr", req_addr, 32'd0);
        // R6: stall until full, requests must stop
        repeat (25) cyc(0, 0, 0, 0, 0);
        #1;
        chk("R6 full stops requests", {31'b0, req_valid}, 32'd0);
        repeat (10) cyc(1, 0, 0, 0, 0);
        // R8: upper-parcel target, then stall and drain
        cyc(0, 0, 0, 1, 32'd101);
        repeat (25) cyc(0, 0, 0, 0, 0);
        #1;
        chk("R6 full stops requests", {31'b0, req_valid}, 32'd0);
        repeat (10) cyc(1, 0, 0, 0, 0);
        // R9: flush right after a request is accepted
        begin
            int guard;
            guard = 0;
            while (!(req_valid && req_ready) && guard < 50) begin
                cyc(1, 0, 0, 0, 0);
                guard++;
            end
        end
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 32'd64);
        repeat (20) cyc(1, 0, 0, 0, 0);
        repeat (3000) cyc(1, 1, 1, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_phase(1'b0);
        run_phase(1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule